// File: doc/BRIEF.md
# Slope-Adaptive Delta Decoder

This block turns a received one-bit-per-sample delta-modulated stream back into signed PCM samples. Each pulse on the bit strobe takes in one serial bit. The bit moves a leaky integrator up by the current slope step for a one, or down by it for a zero. The slope step is companded: it grows while the recent bits agree and decays toward a floor when they do not. A select input chooses whether three or four equal bits in a row count as agreement. Step and integrator follow exactly the same arithmetic as a matching encoder, so an encoder and this decoder fed the same bits hold identical integrator values on every bit.

An active-low idle control replaces the received bits with an internal alternating 0,1,0,1 stream. This holds the step at its floor and the reconstruction at mid-scale. A powersave control, active low, freezes all internal state, ignores strobes and forces the PCM output to zero. Each new sample appears on a registered output, marked by a one-cycle valid pulse. Output filtering and conversion to analogue are left to the logic that follows.

Top module: `cvsd_slope_decoder`

## Requirements
- R1: Synchronous reset sets `pcm_out` to 0, `pcm_vld` to 0, the integrator to 0 and the step to `STEP_MIN`. The first accepted bit after reset is never counted as agreement, so a first bit of 1 gives exactly +`STEP_MIN`.
- R2: For each accepted bit, the integrator first loses its leak, which is its value divided by 2^`LEAK_SH` with truncation toward zero. It then gains the new step for a 1, or loses the new step for a 0.
- R3: With `alg3_sel` = 1, agreement means the new bit equals each of the two bits accepted before it.
- R4: With `alg3_sel` = 0, agreement means the new bit equals each of the three bits accepted before it.
- R5: On agreement the step grows by `STEP_INC`, capped at `STEP_MAX`. Otherwise it shrinks by step / 2^`DECAY_SH` (truncated), floored at `STEP_MIN`. The updated step is the one applied to the same bit.
- R6: The integrator saturates at ±(2^(`PCM_W`-1) − 1).
- R7: While `idle_n` = 0, `rx_bit` is ignored. An internal bit that starts at 0 after reset, and inverts after each idle bit, takes its place in both the integrator and the agreement history. Starting from reset, the output alternates between −`STEP_MIN` and 0.
- R8: While `pwr_on` = 0, strobes are ignored, the step, integrator and history keep their values, `pcm_vld` is 0 and `pcm_out` is 0. After `pwr_on` returns to 1, decoding continues from the held state.
- R9: A strobe accepted at one clock edge updates `pcm_out` and raises `pcm_vld` for exactly the following cycle. Between accepted strobes `pcm_out` holds its value.
- R10: Fed the bits of an encoder that uses the same rule and parameters, `pcm_out` equals that encoder's integrator after every bit, for both agreement rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle pulse per received bit |
| rx_bit | input | 1 | Received serial data bit |
| alg3_sel | input | 1 | 1: three-bit agreement rule, 0: four-bit rule |
| idle_n | input | 1 | Active low: substitute the alternating idle stream |
| pwr_on | input | 1 | Active low powersave: 0 freezes the block |
| pcm_out | output | PCM_W | Signed reconstructed sample |
| pcm_vld | output | 1 | Pulse marking a new sample |

## Verification
The hardest states to reach from the ports are the step ceiling and the integrator rails. Only long runs of agreeing bits get there, and they must be long enough for the step to climb past the leak. The bench drives several hundred equal bits in each direction and compares every sample against an arithmetic model. Resuming after powersave is the other hard case, because the held step and history cannot be seen directly. The bench interrupts a sine-driven stream mid-slope and checks that the first bit after waking lands exactly where the model, continuing from the frozen state, predicts.

// File: rtl/cvsd_dec_pkg.sv
package cvsd_dec_pkg;
  // number of earlier bits kept for the agreement test
  localparam int HIST_W = 3;
  // reset history: newest in bit 0, no two adjacent equal
  localparam logic [HIST_W-1:0] HIST_RST = 3'b010;

  typedef enum logic {
    RULE_FOUR  = 1'b0,
    RULE_THREE = 1'b1
  } rule_e;
endpackage

// File: rtl/cvsd_bit_front.sv
module cvsd_bit_front
  import cvsd_dec_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rx_bit,
  input  logic idle_n,
  input  logic alg3_sel,
  output logic eff_bit,
  output logic coinc
);
  logic [HIST_W-1:0] hist_q;
  logic              alt_q;
  logic              run3, run4;
  rule_e             rule;

  always_comb begin
    rule    = rule_e'(alg3_sel);
    eff_bit = idle_n ? rx_bit : alt_q;
    run3    = (eff_bit == hist_q[0]) && (eff_bit == hist_q[1]);
    run4    = run3 && (eff_bit == hist_q[2]);
    coinc   = (rule == RULE_THREE) ? run3 : run4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= HIST_RST;
      alt_q  <= 1'b0;
    end else if (en) begin
      hist_q <= {hist_q[HIST_W-2:0], eff_bit};
      if (!idle_n) alt_q <= ~alt_q;
    end
  end

  // R7: the idle source inverts after every accepted idle bit
  a_r7_idle_toggles: assert property (@(posedge clk) disable iff (rst)
    (en && !idle_n) |=> (alt_q != $past(alt_q)));
  // R8: history frozen when no bit is accepted
  a_r8_hist_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(hist_q));
endmodule

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt #(
  parameter int W        = 16,
  parameter int STEP_MIN = 16,
  parameter int STEP_MAX = 2048,
  parameter int STEP_INC = 96,
  parameter int DECAY_SH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         coinc,
  output logic [W-1:0] step_nxt
);
  localparam logic [W:0]   MAX_X = (W+1)'(STEP_MAX);
  localparam logic [W:0]   MIN_X = (W+1)'(STEP_MIN);
  localparam logic [W:0]   INC_X = (W+1)'(STEP_INC);
  localparam logic [W-1:0] MIN_S = W'(STEP_MIN);
  localparam logic [W-1:0] MAX_S = W'(STEP_MAX);

  logic [W-1:0] step_q;
  logic [W:0]   grow, shrink;

  always_comb begin
    grow   = {1'b0, step_q} + INC_X;
    shrink = {1'b0, step_q} - {1'b0, step_q >> DECAY_SH};
    if (coinc) step_nxt = (grow > MAX_X)   ? MAX_S : grow[W-1:0];
    else       step_nxt = (shrink < MIN_X) ? MIN_S : shrink[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     step_q <= MIN_S;
    else if (en) step_q <= step_nxt;
  end

  // R5: step always inside its floor and ceiling
  a_r5_step_bounds: assert property (@(posedge clk) disable iff (rst)
    (step_q >= MIN_S) && (step_q <= MAX_S));
  // R5: agreement never lowers the step, disagreement never raises it
  a_r5_step_dir: assert property (@(posedge clk) disable iff (rst)
    (en && coinc) |=> (step_q >= $past(step_q)));
  a_r5_step_decay: assert property (@(posedge clk) disable iff (rst)
    (en && !coinc) |=> (step_q <= $past(step_q)));
endmodule

// File: rtl/cvsd_leaky_integ.sv
module cvsd_leaky_integ #(
  parameter int W       = 16,
  parameter int LEAK_SH = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                up,
  input  logic [W-1:0]        step,
  output logic signed [W-1:0] integ_nxt,
  output logic signed [W-1:0] integ_q
);
  localparam int LIM_I = (1 << (W-1)) - 1;
  localparam logic signed [W+1:0] LIM_X = (W+2)'(LIM_I);
  localparam logic signed [W-1:0] LIM_S = W'(LIM_I);

  logic signed [W+1:0] x, leak, st, sum;

  always_comb begin
    x    = {{2{integ_q[W-1]}}, integ_q};
    leak = x[W+1] ? -((-x) >>> LEAK_SH) : (x >>> LEAK_SH);
    st   = $signed({2'b00, step});
    sum  = x - leak + (up ? st : -st);
    if (sum > LIM_X)       integ_nxt = LIM_S;
    else if (sum < -LIM_X) integ_nxt = -LIM_S;
    else                   integ_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     integ_q <= '0;
    else if (en) integ_q <= integ_nxt;
  end

  // R6: integrator stays within the symmetric rails
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (integ_q >= -LIM_S) && (integ_q <= LIM_S));
  // R2: from zero a one moves up and a zero moves down
  a_r2_up_from_zero: assert property (@(posedge clk) disable iff (rst)
    (en && up && integ_q == 0) |=> (integ_q > 0));
  a_r2_down_from_zero: assert property (@(posedge clk) disable iff (rst)
    (en && !up && integ_q == 0) |=> (integ_q < 0));
endmodule

// File: rtl/cvsd_slope_decoder.sv
module cvsd_slope_decoder #(
  parameter int PCM_W    = 16,
  parameter int STEP_MIN = 16,
  parameter int STEP_MAX = 2048,
  parameter int STEP_INC = 96,
  parameter int DECAY_SH = 4,
  parameter int LEAK_SH  = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_stb,
  input  logic                    rx_bit,
  input  logic                    alg3_sel,
  input  logic                    idle_n,
  input  logic                    pwr_on,
  output logic signed [PCM_W-1:0] pcm_out,
  output logic                    pcm_vld
);
  logic                    take;
  logic                    eff_bit, coinc;
  logic [PCM_W-1:0]        step_use;
  logic signed [PCM_W-1:0] integ_nxt, integ_q;

  assign take = bit_stb & pwr_on;

  cvsd_bit_front u_front (
    .clk(clk), .rst(rst), .en(take), .rx_bit(rx_bit), .idle_n(idle_n),
    .alg3_sel(alg3_sel), .eff_bit(eff_bit), .coinc(coinc)
  );

  cvsd_step_adapt #(
    .W(PCM_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
    .STEP_INC(STEP_INC), .DECAY_SH(DECAY_SH)
  ) u_step (
    .clk(clk), .rst(rst), .en(take), .coinc(coinc), .step_nxt(step_use)
  );

  cvsd_leaky_integ #(.W(PCM_W), .LEAK_SH(LEAK_SH)) u_integ (
    .clk(clk), .rst(rst), .en(take), .up(eff_bit), .step(step_use),
    .integ_nxt(integ_nxt), .integ_q(integ_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_out <= '0;
      pcm_vld <= 1'b0;
    end else if (!pwr_on) begin
      pcm_out <= '0;
      pcm_vld <= 1'b0;
    end else begin
      pcm_vld <= take;
      if (take) pcm_out <= integ_nxt;
    end
  end

  // R9: valid pulse exactly after each accepted strobe
  a_r9_vld_after_take: assert property (@(posedge clk) disable iff (rst)
    take |=> pcm_vld);
  a_r9_vld_only_take: assert property (@(posedge clk) disable iff (rst)
    !take |=> !pcm_vld);
  a_r9_out_held: assert property (@(posedge clk) disable iff (rst)
    (pwr_on && !take) |=> $stable(pcm_out));
  // R8: powersave silences the output and freezes the integrator
  a_r8_out_quiet: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> (pcm_out == '0));
  a_r8_state_held: assert property (@(posedge clk) disable iff (rst)
    !pwr_on |=> $stable(integ_q));
endmodule

// File: tb/test_cvsd_slope_decoder.sv
module test_cvsd_slope_decoder;
  localparam int PCM_W = 16, SMIN = 16, SMAX = 2048, SINC = 96, DSH = 4, LSH = 5;
  localparam int LIM = (1 << (PCM_W-1)) - 1;

  logic clk = 1'b0, rst = 1'b1, bit_stb = 1'b0, rx_bit = 1'b1;
  logic alg3_sel = 1'b1, idle_n = 1'b1, pwr_on = 1'b1;
  logic signed [PCM_W-1:0] pcm_out;
  logic pcm_vld;

  int n_tests = 0, n_fail = 0;
  int m_x, m_step;
  logic [2:0] m_hist;
  logic m_alt;

  always #4 clk = ~clk;

  cvsd_slope_decoder #(.PCM_W(PCM_W), .STEP_MIN(SMIN), .STEP_MAX(SMAX),
    .STEP_INC(SINC), .DECAY_SH(DSH), .LEAK_SH(LSH)) i_cvsd_slope_decoder (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .rx_bit(rx_bit), .alg3_sel(alg3_sel),
    .idle_n(idle_n), .pwr_on(pwr_on), .pcm_out(pcm_out), .pcm_vld(pcm_vld));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_x = 0; m_step = SMIN; m_hist = 3'b010; m_alt = 1'b0;
  endtask

  // arithmetic model of one accepted bit, from the requirements
  task automatic model_bit(input bit b);
    bit e, r3, r4, c;
    int lk, y;
    e  = idle_n ? b : m_alt;
    r3 = (e == m_hist[0]) && (e == m_hist[1]);
    r4 = r3 && (e == m_hist[2]);
    c  = alg3_sel ? r3 : r4;
    if (c) m_step = (m_step + SINC > SMAX) ? SMAX : m_step + SINC;
    else   m_step = (m_step - m_step / (1 << DSH) < SMIN) ? SMIN : m_step - m_step / (1 << DSH);
    lk = m_x / (1 << LSH);
    y  = m_x - lk + (e ? m_step : -m_step);
    m_x = (y > LIM) ? LIM : ((y < -LIM) ? -LIM : y);
    m_hist = {m_hist[1:0], e};
    if (!idle_n) m_alt = ~m_alt;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one strobe; sample after the capturing edge
  task automatic send(input bit b, input string req);
    @(negedge clk); bit_stb = 1'b1; rx_bit = b;
    model_bit(b);
    @(negedge clk); bit_stb = 1'b0;
    check(pcm_vld == 1'b1 && pcm_out == m_x, req, int'(pcm_out), m_x);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(pcm_out == 0 && pcm_vld == 0, "R1 reset outputs", int'(pcm_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pcm_out == 0 && pcm_vld == 0, "R1 idle after reset", int'(pcm_vld), 0);

    // R1: first one after reset gives +STEP_MIN
    send(1'b1, "R1 first bit");
    check(pcm_out == SMIN, "R1 first step", int'(pcm_out), SMIN);
    @(negedge clk);
    check(pcm_vld == 0, "R9 single-cycle valid", int'(pcm_vld), 0);
    check(pcm_out == SMIN, "R9 output held", int'(pcm_out), SMIN);

    // R2 R3 R4 R5: every 8-bit pattern under each rule
    for (int a = 0; a < 2; a++) begin
      alg3_sel = a[0];
      do_reset();
      for (int v = 0; v < 256; v++)
        for (int k = 0; k < 8; k++)
          send(v[k], a ? "R3 R2 R5 pattern sweep" : "R4 R2 R5 pattern sweep");
    end

    // R5 R6: long runs reach the step ceiling and both rails
    alg3_sel = 1'b0;
    do_reset();
    for (int i = 0; i < 400; i++) send(1'b1, "R5 R6 ones run");
    check(pcm_out == LIM, "R6 upper rail", int'(pcm_out), LIM);
    check(m_step == SMAX, "R5 ceiling reached", m_step, SMAX);
    for (int i = 0; i < 400; i++) send(1'b0, "R5 R6 zeros run");
    check(pcm_out == -LIM, "R6 lower rail", int'(pcm_out), -LIM);

    // R10: bench encoder tracking a sine, both rules
    for (int a = 0; a < 2; a++) begin
      alg3_sel = a[0];
      do_reset();
      for (int i = 0; i < 1000; i++) begin
        int tgt;
        tgt = $rtoi(9000.0 * $sin(2.0 * 3.14159265 * i / 40.0));
        send(tgt > m_x, "R10 encoder tracking");
      end
    end

    // R8: powersave mid-slope, then resume from held state
    alg3_sel = 1'b1;
    for (int i = 0; i < 7; i++) send(1'b1, "R10 pre-sleep");
    @(negedge clk); pwr_on = 1'b0;
    @(negedge clk);
    check(pcm_out == 0 && pcm_vld == 0, "R8 output quiet", int'(pcm_out), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); bit_stb = 1'b1; rx_bit = i[0];
      @(negedge clk); bit_stb = 1'b0;
      check(pcm_vld == 0 && pcm_out == 0, "R8 strobe ignored", int'(pcm_vld), 0);
    end
    @(negedge clk); pwr_on = 1'b1;
    send(1'b1, "R8 resume from held state");
    send(1'b1, "R8 resume second bit");

    // R7: idle from reset alternates -STEP_MIN and 0, rx ignored
    do_reset();
    idle_n = 1'b0;
    for (int i = 0; i < 200; i++) begin
      send(1'b1, "R7 idle from reset");
      check(pcm_out == ((i % 2 == 0) ? -SMIN : 0), "R7 idle level",
            int'(pcm_out), (i % 2 == 0) ? -SMIN : 0);
    end

    // R7: idle entered after loud data settles near mid-scale
    idle_n = 1'b1;
    for (int i = 0; i < 60; i++) send(1'b1, "R7 pre-idle data");
    idle_n = 1'b0;
    for (int i = 0; i < 600; i++) send(i[0], "R7 idle settling");
    check(pcm_out <= (1 << LSH) + SMIN && pcm_out >= -((1 << LSH) + SMIN),
          "R7 settled near mid-scale", int'(pcm_out), 0);
    idle_n = 1'b1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule